// File: doc/BRIEF.md
# Cut-Through Threshold Receive FIFO

This block buffers received frames between a MAC receive path and a packet-oriented system interface. Words of 64 bits (eight bytes) are written on the input side with start, end and error markers and a count of valid bytes in the last word. A per-packet release rule decides when the frame at the head may start leaving on the output side. Release happens when the frame is complete, or when its stored word count reaches a programmable occupancy threshold. Short frames are therefore forwarded store-and-forward. Long frames start cut-through, before their final word has arrived.

The threshold is counted in eight-byte storage locations and lives in a 12-bit field. Illegal values are clamped. The floor is 190 locations (1520 bytes), and the ceiling is one below a second programmable high-watermark field. A sticky overflow flag records writes that were dropped because the store was full. The output side uses a valid/ready handshake and carries the sideband markers with every word. An error marker on a final word passes through unchanged, so downstream logic can discard a bad frame that was already streaming.

Top module: `ct_rx_fifo`

## Requirements
- R1: After reset, out_valid is 0, the threshold field reads 0x0BE, the high-watermark field reads 0x180 and the status field reads 0.
- R2: Register address 0 holds the threshold in bits 11:0, and bits 31:12 of every register read as zero. A write of a value below 0x0BE (taken from wdata bits 11:0) stores 0x0BE.
- R3: A threshold write at or above the current high watermark (address 1, bits 11:0) stores the high watermark minus one. High-watermark writes store wdata bits 11:0 unchanged.
- R4: If a frame's final word is written while the frame holds fewer stored words than the threshold, out_valid stays 0 until the clock edge that stores that final word, and it is 1 after that edge.
- R5: When the frame at the head has stored as many words as the threshold, out_valid is 1 after that edge, although no final word has been written yet.
- R6: Once a frame has begun to leave, it keeps streaming until its final word is read. out_valid is 0 only while no stored word is left, and it returns to 1 after the next write. After the final word is read, the next frame again waits under R4 or R5.
- R7: Each output word carries the data, start, end, error and byte-count values written with it. The byte count is 3 bits, and 0 means all eight bytes are valid. Frames leave in write order.
- R8: A write while DEPTH words are stored is dropped and sets status bit 0. That bit stays set until any write to register address 2 clears it.
- R9: While out_valid is 1 and out_ready is 0, and no register is written, out_valid stays 1 and out_data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Write strobe for one word |
| in_data | input | 64 | Eight data bytes |
| in_sop | input | 1 | First word of a frame |
| in_eop | input | 1 | Final word of a frame |
| in_err | input | 1 | Frame error, meaningful on the final word |
| in_nbytes | input | 3 | Valid bytes in the final word, 0 means eight |
| out_ready | input | 1 | Consumer accepts the presented word |
| out_valid | output | 1 | A releasable word is presented |
| out_data | output | 64 | Presented data bytes |
| out_sop | output | 1 | Presented word starts a frame |
| out_eop | output | 1 | Presented word ends a frame |
| out_err | output | 1 | Error marker of the presented word |
| out_nbytes | output | 3 | Byte count of the presented word |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 threshold, 1 high watermark, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |

## Verification
The assertions assume that every frame opens with a start-marked word and closes with exactly one end-marked word, and that the handshake hold check only applies while no register write can move the threshold. The stimulus writes whole, well-formed frames. It fills the store past DEPTH only in the overflow test, where no final word is lost before the test ends with a reset. Register writes happen only while the output side is idle.

// File: rtl/ctrx_pkg.sv
package ctrx_pkg;

    localparam int WORD_BITS = 64;

    typedef struct packed {
        logic [WORD_BITS-1:0] data;
        logic                 sop;
        logic                 eop;
        logic                 err;
        logic [2:0]           nbytes;
    } word_t;

    typedef enum logic [1:0] {
        RA_THR  = 2'd0,
        RA_HWM  = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/ctrx_regs.sv
module ctrx_regs #(
    parameter int          FIELD_W = 12,
    parameter logic [11:0] THR_MIN = 12'h0BE,
    parameter logic [11:0] HWM_RST = 12'h180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    input  logic               ovf_evt,
    output logic [31:0]        reg_rdata,
    output logic [FIELD_W-1:0] thr,
    output logic               ovf_flag
);
    import ctrx_pkg::*;

    typedef struct packed {
        logic [FIELD_W-1:0] thr;
        logic [FIELD_W-1:0] hwm;
        logic               ovf;
    } rstate_t;

    rstate_t st_d, st_q;
    logic [FIELD_W-1:0] wr_field;
    logic [FIELD_W-1:0] hwm_m1;
    logic [FIELD_W-1:0] thr_clamped;

    always_comb begin
        st_d        = st_q;
        wr_field    = reg_wdata[FIELD_W-1:0];
        hwm_m1      = st_q.hwm - FIELD_W'(1);
        thr_clamped = wr_field;
        if (thr_clamped > hwm_m1) begin
            thr_clamped = hwm_m1;
        end
        if (thr_clamped < FIELD_W'(THR_MIN)) begin
            thr_clamped = FIELD_W'(THR_MIN);
        end
        if (reg_wr) begin
            unique case (reg_addr_e'(reg_addr))
                RA_THR:  st_d.thr = thr_clamped;
                RA_HWM:  st_d.hwm = wr_field;
                RA_STAT: st_d.ovf = 1'b0;
                default: ;
            endcase
        end
        if (ovf_evt) begin
            st_d.ovf = 1'b1;
        end
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            RA_THR:  reg_rdata[FIELD_W-1:0] = st_q.thr;
            RA_HWM:  reg_rdata[FIELD_W-1:0] = st_q.hwm;
            RA_STAT: reg_rdata[0]           = st_q.ovf;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr <= FIELD_W'(THR_MIN);
            st_q.hwm <= FIELD_W'(HWM_RST);
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr      = st_q.thr;
    assign ovf_flag = st_q.ovf;

endmodule

// File: rtl/ctrx_store.sv
module ctrx_store #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  ctrx_pkg::word_t      wr_word,
    input  logic [AW-1:0]        rd_addr,
    output ctrx_pkg::word_t      rd_word
);
    ctrx_pkg::word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end
    end

    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/ctrx_gate.sv
module ctrx_gate #(
    parameter int  DEPTH   = 512,
    parameter int  FIELD_W = 12,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_eop,
    input  logic               out_ready,
    input  logic               head_eop,
    input  logic [FIELD_W-1:0] thr,
    output logic               wr_en,
    output logic [AW-1:0]      wr_addr,
    output logic [AW-1:0]      rd_addr,
    output logic               out_valid,
    output logic               full,
    output logic               ovf_evt,
    output logic [CW-1:0]      occupancy
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic [CW-1:0] eops;
        logic          streaming;
    } gstate_t;

    gstate_t st_d, st_q;
    logic    wr_fire;
    logic    rd_fire;
    logic    released;

    always_comb begin
        st_d      = st_q;
        full      = (st_q.count == CW'(DEPTH));
        wr_fire   = in_valid && !full;
        ovf_evt   = in_valid && full;
        // head frame: complete, past threshold, or already leaving
        released  = (st_q.eops != '0)
                 || (32'(st_q.count) >= 32'(thr))
                 || st_q.streaming;
        out_valid = (st_q.count != '0) && released;
        rd_fire   = out_valid && out_ready;

        st_d.wr_ptr = st_q.wr_ptr + AW'(wr_fire);
        st_d.rd_ptr = st_q.rd_ptr + AW'(rd_fire);
        st_d.count  = st_q.count + CW'(wr_fire) - CW'(rd_fire);
        st_d.eops   = st_q.eops + CW'(wr_fire && in_eop)
                                - CW'(rd_fire && head_eop);
        if (rd_fire) begin
            st_d.streaming = !head_eop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en     = wr_fire;
    assign wr_addr   = st_q.wr_ptr;
    assign rd_addr   = st_q.rd_ptr;
    assign occupancy = st_q.count;

endmodule

// File: rtl/ct_rx_fifo.sv
module ct_rx_fifo #(
    parameter int          DEPTH   = 512,
    parameter int          FIELD_W = 12,
    parameter logic [11:0] THR_MIN = 12'h0BE,
    parameter logic [11:0] HWM_RST = 12'h180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [63:0] in_data,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic        in_err,
    input  logic [2:0]  in_nbytes,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [63:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic        out_err,
    output logic [2:0]  out_nbytes,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    import ctrx_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [FIELD_W-1:0] thr;
    logic               ovf_flag;
    logic               ovf_evt;
    logic               fifo_full;
    logic [CW-1:0]      occupancy;
    logic               wr_en;
    logic [AW-1:0]      wr_addr;
    logic [AW-1:0]      rd_addr;
    word_t              wr_word;
    word_t              rd_word;

    assign wr_word = '{data: in_data, sop: in_sop, eop: in_eop,
                       err: in_err, nbytes: in_nbytes};

    ctrx_regs #(
        .FIELD_W(FIELD_W), .THR_MIN(THR_MIN), .HWM_RST(HWM_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ovf_evt(ovf_evt), .reg_rdata(reg_rdata),
        .thr(thr), .ovf_flag(ovf_flag)
    );

    ctrx_gate #(.DEPTH(DEPTH), .FIELD_W(FIELD_W)) i_gate (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
        .out_ready(out_ready), .head_eop(rd_word.eop), .thr(thr),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .out_valid(out_valid), .full(fifo_full), .ovf_evt(ovf_evt),
        .occupancy(occupancy)
    );

    ctrx_store #(.DEPTH(DEPTH)) i_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_word(wr_word),
        .rd_addr(rd_addr), .rd_word(rd_word)
    );

    assign out_data   = rd_word.data;
    assign out_sop    = rd_word.sop;
    assign out_eop    = rd_word.eop;
    assign out_err    = rd_word.err;
    assign out_nbytes = rd_word.nbytes;

endmodule

// File: rtl/ctrx_checker.sv
module ctrx_checker #(
    parameter int          DEPTH   = 512,
    parameter logic [11:0] THR_MIN = 12'h0BE,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic          out_ready,
    input logic [63:0]   out_data,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_rdata,
    input logic          fifo_full,
    input logic [CW-1:0] occupancy,
    input logic          ovf_flag
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:12] == '0);

    a_r2_thr_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[11:0] >= THR_MIN));

    a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fifo_full) |=> ovf_flag);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !(reg_wr && reg_addr == 2'd2)) |=> ovf_flag);

    a_r8_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CW'(DEPTH));

    a_r6_no_valid_empty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occupancy != '0));

    a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !reg_wr) |=> out_valid);

    a_r9_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !reg_wr) |=> $stable(out_data));

endmodule

bind ct_rx_fifo ctrx_checker #(.DEPTH(DEPTH), .THR_MIN(THR_MIN)) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .fifo_full(fifo_full),
    .occupancy(occupancy), .ovf_flag(ovf_flag)
);

// File: tb/test_ct_rx_fifo.sv
module test_ct_rx_fifo;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic        in_err = 1'b0;
    logic [2:0]  in_nbytes = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_sop;
    logic        out_eop;
    logic        out_err;
    logic [2:0]  out_nbytes;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd3;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ct_rx_fifo i_ct_rx_fifo (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
        .in_nbytes(in_nbytes), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .out_nbytes(out_nbytes), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct packed {
        logic [1:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } rvec_t;

    // R2 / R3 register vectors: write, then read back the same address
    localparam rvec_t REG_TBL [10] = '{
        '{2'd0, 32'h0000_0010, 32'h0000_00BE},
        '{2'd0, 32'h0000_00C8, 32'h0000_00C8},
        '{2'd0, 32'h0000_017F, 32'h0000_017F},
        '{2'd0, 32'h0000_0180, 32'h0000_017F},
        '{2'd0, 32'hFFFF_FFFF, 32'h0000_017F},
        '{2'd1, 32'hABC0_0200, 32'h0000_0200},
        '{2'd0, 32'h0000_01F0, 32'h0000_01F0},
        '{2'd1, 32'h0000_0180, 32'h0000_0180},
        '{2'd0, 32'h0000_0000, 32'h0000_00BE},
        '{2'd2, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [63:0] d, input logic s, input logic e,
                        input logic er, input logic [2:0] nb);
        in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e;
        in_err = er; in_nbytes = nb;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
    endtask

    task automatic pop_chk(input logic [63:0] d, input logic s, input logic e,
                           input logic er, input logic [2:0] nb,
                           input string req);
        chk(out_valid && out_data == d && out_sop == s && out_eop == e &&
            out_err == er && out_nbytes == nb, req,
            {out_valid, out_sop, out_eop, out_err, out_nbytes, out_data[55:0]},
            {1'b1, s, e, er, nb, d[55:0]});
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        logic [63:0] held;
        do_reset();

        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
        reg_read(2'd0, rv);
        chk(rv == 32'h0BE, "R1 threshold", 64'(rv), 64'h0BE);
        reg_read(2'd1, rv);
        chk(rv == 32'h180, "R1 high watermark", 64'(rv), 64'h180);
        reg_read(2'd2, rv);
        chk(rv == 32'h0, "R1 status", 64'(rv), 64'h0);

        // R2 R3: register table walk
        foreach (REG_TBL[i]) begin
            reg_write(REG_TBL[i].addr, REG_TBL[i].wdata);
            reg_read(REG_TBL[i].addr, rv);
            chk(rv == REG_TBL[i].expect_rd, $sformatf("R2 R3 table entry %0d", i),
                64'(rv), 64'(REG_TBL[i].expect_rd));
        end

        // R4: short frame waits for its final word
        for (int k = 0; k < 4; k++) begin
            push(64'hA000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0);
            chk(out_valid == 1'b0, $sformatf("R4 held after word %0d", k),
                64'(out_valid), 64'd0);
        end
        push(64'hA000_0000_0000_0004, 1'b0, 1'b1, 1'b0, 3'd5);
        chk(out_valid == 1'b1, "R4 released on final word", 64'(out_valid), 64'd1);

        // R9: hold while not ready
        held = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid && out_data == held, "R9 hold", out_data, held);

        // R7: contents and sideband
        for (int k = 0; k < 4; k++) begin
            pop_chk(64'hA000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0,
                    $sformatf("R7 short frame word %0d", k));
        end
        pop_chk(64'hA000_0000_0000_0004, 1'b0, 1'b1, 1'b0, 3'd5, "R7 short frame end");
        chk(out_valid == 1'b0, "R7 drained", 64'(out_valid), 64'd0);

        // R5: long frame released at the threshold (190 words)
        for (int k = 0; k < 189; k++) begin
            push(64'hB000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0);
        end
        chk(out_valid == 1'b0, "R5 below threshold", 64'(out_valid), 64'd0);
        push(64'hB000_0000_0000_00BD, 1'b0, 1'b0, 1'b0, 3'd0);
        chk(out_valid == 1'b1 && out_sop == 1'b1, "R5 cut-through start",
            64'({out_valid, out_sop}), 64'd3);

        // R6: stream, catch up, resume
        for (int k = 0; k < 190; k++) begin
            pop_chk(64'hB000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0,
                    $sformatf("R6 stream word %0d", k));
        end
        chk(out_valid == 1'b0, "R6 caught up", 64'(out_valid), 64'd0);
        push(64'hB000_0000_0000_00BE, 1'b0, 1'b0, 1'b0, 3'd0);
        chk(out_valid == 1'b1, "R6 resumes below threshold", 64'(out_valid), 64'd1);
        push(64'hB000_0000_0000_00BF, 1'b0, 1'b1, 1'b1, 3'd3);
        pop_chk(64'hB000_0000_0000_00BE, 1'b0, 1'b0, 1'b0, 3'd0, "R6 tail word");
        pop_chk(64'hB000_0000_0000_00BF, 1'b0, 1'b1, 1'b1, 3'd3, "R7 error on final word");

        // R6: the next frame waits again after the final word left
        push(64'hC000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 3'd0);
        chk(out_valid == 1'b0, "R6 next frame waits", 64'(out_valid), 64'd0);
        push(64'hC000_0000_0000_0001, 1'b0, 1'b1, 1'b0, 3'd1);
        push(64'hD000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 3'd2);
        pop_chk(64'hC000_0000_0000_0000, 1'b1, 1'b0, 1'b0, 3'd0, "R7 order frame C start");
        pop_chk(64'hC000_0000_0000_0001, 1'b0, 1'b1, 1'b0, 3'd1, "R7 order frame C end");
        pop_chk(64'hD000_0000_0000_0000, 1'b1, 1'b1, 1'b0, 3'd2, "R7 order frame D");

        // R8: overflow drops the write and sets the sticky flag
        do_reset();
        for (int k = 0; k < 512; k++) begin
            push(64'hE000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0);
        end
        reg_read(2'd2, rv);
        chk(rv == 32'h0, "R8 no flag when just full", 64'(rv), 64'h0);
        push(64'hEEEE_EEEE_EEEE_EEEE, 1'b0, 1'b0, 1'b0, 3'd0);
        reg_read(2'd2, rv);
        chk(rv == 32'h1, "R8 flag set", 64'(rv), 64'h1);
        repeat (2) @(negedge clk);
        reg_read(2'd2, rv);
        chk(rv == 32'h1, "R8 flag sticky", 64'(rv), 64'h1);
        for (int k = 0; k < 512; k++) begin
            pop_chk(64'hE000_0000_0000_0000 | 64'(k), k == 0, 1'b0, 1'b0, 3'd0,
                    $sformatf("R8 stored word %0d", k));
        end
        chk(out_valid == 1'b0, "R8 dropped word absent", 64'(out_valid), 64'd0);
        reg_write(2'd2, 32'h0);
        reg_read(2'd2, rv);
        chk(rv == 32'h0, "R8 flag cleared", 64'(rv), 64'h0);
        do_reset();

        finish_run();
    end

endmodule